// File: doc/BRIEF.md
# Multiplexed Bus Glue with Restart Injection

This block sits between a processor that shares one 8-bit bus for address, cycle type and data, and the memory and port hardware around it. The processor reports which part of a machine cycle it is in through a 3-bit state code, qualified by a one-cycle sync strobe per state. The glue takes the low address byte in the first address state. It takes the upper six address bits and a 2-bit cycle type in the second address state. This builds a 14-bit memory address register covering 16K bytes. In the data state it drives memory or port read data back onto the bus, or it pulses a write strobe.

The glue keeps the last opcode fetched. When an I/O cycle follows that opcode, the port number is decoded from it and a one-hot strobe is raised for one of 8 input ports or one of 24 output ports. An interrupt request is held pending until the processor reports the acknowledge state. On the fetch that follows, the glue puts a one-byte restart opcode carrying the request's vector on the bus in place of memory data. It then clears the request.

Top module: `mbus_glue`

## Requirements
- R1: After reset the address register and the cycle type read zero, every strobe is low and the bus drive enable is low.
- R2: In a sync-qualified first address state (code 3'b010) or acknowledge state (code 3'b011), bus bits [7:0] are stored as address bits [7:0]; they appear on the address output from the next cycle.
- R3: In a sync-qualified second address state (code 3'b100), bus bits [5:0] become address bits [13:8] and bus bits [7:6] become the cycle type: 00 fetch, 01 memory read, 10 I/O, 11 memory write.
- R4: In a sync-qualified data state (code 3'b001) of a fetch or a memory-read cycle with no injection armed, the memory read strobe is high and the memory read data is driven onto the bus.
- R5: In the data state of a memory-write cycle, only the memory write strobe is high, for exactly that cycle, and the bus is not driven.
- R6: An I/O cycle whose last fetched opcode is 01_00_PPP_1 raises input strobe bit PPP alone and drives the port read data onto the bus.
- R7: An I/O cycle whose last fetched opcode is 01_PPPPP_1 with PPPPP of 8 or more raises output strobe bit PPPPP-8 alone and does not drive the bus.
- R8: An interrupt request, even a one-cycle pulse, stays pending. An acknowledge state seen while it is pending arms injection. The next fetch data state then drives 00_VVV_101, with VVV the vector input, and raises no memory read strobe.
- R9: Once the restart byte has been driven, the request is cleared and the next fetch returns memory data.
- R10: A pending request does not alter a fetch whose first address state uses the ordinary code 3'b010.
- R11: A state code presented with sync low changes no register and raises no strobe or bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 8 | Value the processor places on the shared bus |
| st_i | input | 3 | Processor state code |
| sync_i | input | 1 | One-cycle qualifier for the state code |
| int_req_i | input | 1 | Interrupt request |
| int_vec_i | input | 3 | Restart vector for the injected opcode |
| mem_rdata_i | input | 8 | Memory read data |
| io_rdata_i | input | 8 | Input port read data |
| mar_o | output | 14 | Latched memory address |
| cyc_o | output | 2 | Latched cycle type |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| in_stb_o | output | 8 | One-hot input port strobes |
| out_stb_o | output | 24 | One-hot output port strobes, bit 0 is port 8 |
| bus_out_o | output | 8 | Byte driven toward the processor |
| bus_oe_o | output | 1 | Bus drive enable |

## Verification
The address path is tried with distinct low and high bytes whose upper two bits differ from the address bits. This tells a correct split of cycle type from address apart from a shifted or overlapping one. The port decoder gets one input opcode and two output opcodes, the lowest output port and a middle one. These separate the input/output boundary from an off-by-eight index. The interrupt path is run three ways: a one-cycle request pulse before an acknowledge, a request seen only by an ordinary fetch, and the fetch after an injection. These show that the request is held, that only the acknowledge code arms injection, and that the request is cleared afterwards.

// File: rtl/mbus_glue_pkg.sv
package mbus_glue_pkg;

  localparam logic [2:0] ST_ADDR_LO = 3'b010;
  localparam logic [2:0] ST_ACK_LO  = 3'b011;
  localparam logic [2:0] ST_ADDR_HI = 3'b100;
  localparam logic [2:0] ST_DATA    = 3'b001;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_MRD   = 2'b01,
    CYC_IO    = 2'b10,
    CYC_MWR   = 2'b11
  } cyc_e;

  function automatic logic [7:0] restart_op(input logic [2:0] vec);
    return {2'b00, vec, 3'b101};
  endfunction

endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_en,
  input  logic              hi_en,
  input  logic [DATA_W-1:0] bus,
  output logic [ADDR_W-1:0] mar,
  output logic [1:0]        cyc
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] lo_q, lo_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic [1:0]        cyc_q, cyc_n;

  always_comb begin
    lo_n  = lo_q;
    hi_n  = hi_q;
    cyc_n = cyc_q;
    if (lo_en) lo_n = bus;
    if (hi_en) begin
      hi_n  = bus[HI_W-1:0];
      cyc_n = bus[DATA_W-1 -: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cyc_q <= '0;
    end else begin
      lo_q  <= lo_n;
      hi_q  <= hi_n;
      cyc_q <= cyc_n;
    end
  end

  assign mar = {hi_q, lo_q};
  assign cyc = cyc_q;
endmodule

// File: rtl/mbus_int_jam.sv
module mbus_int_jam (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack_seen,
  input  logic jam_done,
  output logic armed
);
  logic pend_q, pend_n;
  logic arm_q, arm_n;

  always_comb begin
    pend_n = pend_q;
    arm_n  = arm_q;
    if (jam_done) begin
      pend_n = 1'b0;
      arm_n  = 1'b0;
    end else begin
      if (req) pend_n = 1'b1;
      if (ack_seen && pend_q) arm_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      arm_q  <= arm_n;
    end
  end

  assign armed = arm_q;
endmodule

// File: rtl/mbus_port_dec.sv
module mbus_port_dec #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 24
) (
  input  logic [7:0]       opcode,
  input  logic             io_en,
  output logic             is_in,
  output logic [N_IN-1:0]  in_stb,
  output logic [N_OUT-1:0] out_stb
);
  localparam int PORT_W = $clog2(N_IN + N_OUT);

  logic [PORT_W-1:0] port;
  logic              io_op;
  logic              is_out;

  assign port   = opcode[PORT_W:1];
  assign io_op  = (opcode[7:6] == 2'b01) && opcode[0];
  assign is_in  = io_op && (int'(port) < N_IN);
  assign is_out = io_op && (int'(port) >= N_IN);

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign in_stb[i] = io_en && is_in && (int'(port) == i);
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    assign out_stb[j] = io_en && is_out && (int'(port) == j + N_IN);
  end
endmodule

// File: rtl/mbus_glue.sv
module mbus_glue
  import mbus_glue_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int N_IN   = 8,
  parameter int N_OUT  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [2:0]        st_i,
  input  logic              sync_i,
  input  logic              int_req_i,
  input  logic [2:0]        int_vec_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] io_rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [1:0]        cyc_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [N_IN-1:0]   in_stb_o,
  output logic [N_OUT-1:0]  out_stb_o,
  output logic [DATA_W-1:0] bus_out_o,
  output logic              bus_oe_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic lo_en, hi_en, ack_en, data_st;
  assign ack_en  = sync_i && (st_i == ST_ACK_LO);
  assign lo_en   = (sync_i && (st_i == ST_ADDR_LO)) || ack_en;
  assign hi_en   = sync_i && (st_i == ST_ADDR_HI);
  assign data_st = sync_i && (st_i == ST_DATA);

  logic [1:0] cyc;
  mbus_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .lo_en (lo_en),
    .hi_en (hi_en),
    .bus   (bus_i),
    .mar   (mar_o),
    .cyc   (cyc)
  );
  assign cyc_o = cyc;

  logic fetch_dat, mrd_dat, mwr_dat, io_dat;
  assign fetch_dat = data_st && (cyc == CYC_FETCH);
  assign mrd_dat   = data_st && (cyc == CYC_MRD);
  assign mwr_dat   = data_st && (cyc == CYC_MWR);
  assign io_dat    = data_st && (cyc == CYC_IO);

  logic armed, jam_now;
  assign jam_now = fetch_dat && armed;

  mbus_int_jam u_jam (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (int_req_i),
    .ack_seen (ack_en),
    .jam_done (jam_now),
    .armed    (armed)
  );

  logic [DATA_W-1:0] op_q, op_n;
  logic              is_in;

  mbus_port_dec #(.N_IN(N_IN), .N_OUT(N_OUT)) u_dec (
    .opcode  (op_q),
    .io_en   (io_dat),
    .is_in   (is_in),
    .in_stb  (in_stb_o),
    .out_stb (out_stb_o)
  );

  logic [DATA_W-1:0] drive_n;
  logic              oe_n;

  always_comb begin
    drive_n = '0;
    oe_n    = 1'b0;
    if (jam_now) begin
      drive_n = restart_op(int_vec_i);
      oe_n    = 1'b1;
    end else if (fetch_dat || mrd_dat) begin
      drive_n = mem_rdata_i;
      oe_n    = 1'b1;
    end else if (io_dat && is_in) begin
      drive_n = io_rdata_i;
      oe_n    = 1'b1;
    end
  end

  always_comb begin
    op_n = op_q;
    if (fetch_dat) op_n = drive_n;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) op_q <= '0;
    else            op_q <= op_n;
  end

  assign mem_rd_o  = (fetch_dat && !armed) || mrd_dat;
  assign mem_wr_o  = mwr_dat;
  assign bus_out_o = drive_n;
  assign bus_oe_o  = oe_n;
endmodule

// File: rtl/mbus_glue_chk.sv
module mbus_glue_chk #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_i,
  input logic [2:0]       st_i,
  input logic             sync_i,
  input logic [13:0]      mar_o,
  input logic [1:0]       cyc_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic [N_IN-1:0]  in_stb_o,
  input logic [N_OUT-1:0] out_stb_o,
  input logic             bus_oe_o
);
  // R2
  lo_addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && (st_i == 3'b010 || st_i == 3'b011)) |=> (mar_o[7:0] == $past(bus_i)));

  // R3
  hi_addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && st_i == 3'b100) |=> (cyc_o == $past(bus_i[7:6]) && mar_o[13:8] == $past(bus_i[5:0])));

  // R5
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (!bus_oe_o && !mem_rd_o && cyc_o == 2'b11));

  // R6
  in_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb_o != '0) |-> ($onehot0(in_stb_o) && cyc_o == 2'b10 && bus_oe_o));

  // R7
  out_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb_o != '0) |-> ($onehot0(out_stb_o) && in_stb_o == '0 && !bus_oe_o));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |-> (!mem_rd_o && !mem_wr_o && !bus_oe_o && in_stb_o == '0 && out_stb_o == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> ($stable(mar_o) && $stable(cyc_o)));
endmodule

bind mbus_glue mbus_glue_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_i     (bus_i),
  .st_i      (st_i),
  .sync_i    (sync_i),
  .mar_o     (mar_o),
  .cyc_o     (cyc_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .in_stb_o  (in_stb_o),
  .out_stb_o (out_stb_o),
  .bus_oe_o  (bus_oe_o)
);

// File: tb/mbus_glue_tb.sv
module mbus_glue_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_i;
  logic [2:0]  st_i;
  logic        sync_i;
  logic        int_req_i;
  logic [2:0]  int_vec_i;
  logic [7:0]  mem_rdata_i;
  logic [7:0]  io_rdata_i;
  logic [13:0] mar_o;
  logic [1:0]  cyc_o;
  logic        mem_rd_o;
  logic        mem_wr_o;
  logic [7:0]  in_stb_o;
  logic [23:0] out_stb_o;
  logic [7:0]  bus_out_o;
  logic        bus_oe_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mbus_glue u_dut (
    .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .st_i(st_i), .sync_i(sync_i),
    .int_req_i(int_req_i), .int_vec_i(int_vec_i), .mem_rdata_i(mem_rdata_i),
    .io_rdata_i(io_rdata_i), .mar_o(mar_o), .cyc_o(cyc_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .in_stb_o(in_stb_o), .out_stb_o(out_stb_o),
    .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one state at a negedge, sample 2 ns later (before the next posedge)
  task automatic step(input logic [2:0] st, input logic sy, input logic [7:0] b);
    @(negedge clk);
    st_i = st; sync_i = sy; bus_i = b;
    #2;
  endtask

  task automatic idle();
    step(3'b000, 1'b0, 8'h00);
  endtask

  // address states only; leaves the bench ready for the data state
  task automatic addr(input logic ack, input logic [1:0] typ, input logic [13:0] a);
    step(ack ? 3'b011 : 3'b010, 1'b1, a[7:0]);
    step(3'b100, 1'b1, {typ, a[13:8]});
  endtask

  task automatic fetch(input logic [13:0] a, input logic [7:0] op);
    addr(1'b0, 2'b00, a);
    mem_rdata_i = op;
    step(3'b001, 1'b1, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 mar", 32'(mar_o), 0);
    check("R1 cyc", 32'(cyc_o), 0);
    check("R1 strobes", {mem_rd_o, mem_wr_o, bus_oe_o, 5'b0, in_stb_o, out_stb_o[15:0]}, 0);
  endtask

  task automatic t_addr();
    addr(1'b0, 2'b01, 14'h2A5C);
    idle();
    check("R2 low addr", 32'(mar_o[7:0]), 32'h5C);
    check("R3 high addr", 32'(mar_o[13:8]), 32'h2A);
    check("R3 cyc type", 32'(cyc_o), 32'h1);
  endtask

  task automatic t_mem_read();
    addr(1'b0, 2'b01, 14'h1234);
    mem_rdata_i = 8'hC7;
    step(3'b001, 1'b1, 8'h00);
    check("R4 rd strobe", 32'(mem_rd_o), 1);
    check("R4 drive", {23'b0, bus_oe_o, bus_out_o}, 32'h1C7);
    idle();
  endtask

  task automatic t_mem_write();
    addr(1'b0, 2'b11, 14'h3FFF);
    step(3'b001, 1'b1, 8'h99);
    check("R5 wr strobe", {mem_wr_o, mem_rd_o, bus_oe_o}, 3'b100);
    idle();
    check("R5 wr one cycle", 32'(mem_wr_o), 0);
    check("R3 all-ones addr", 32'(mar_o), 32'h3FFF);
  endtask

  task automatic t_input();
    fetch(14'h0100, 8'h47);           // 01_00_011_1 -> input port 3
    idle();
    addr(1'b0, 2'b10, 14'h0000);
    io_rdata_i = 8'h3E;
    step(3'b001, 1'b1, 8'h00);
    check("R6 in strobe", 32'(in_stb_o), 32'h08);
    check("R6 drive", {23'b0, bus_oe_o, bus_out_o}, 32'h13E);
    check("R6 no out", 32'(out_stb_o), 0);
    idle();
  endtask

  task automatic t_output(input logic [4:0] port);
    fetch(14'h0101, {2'b01, port, 1'b1});
    idle();
    addr(1'b0, 2'b10, 14'h0000);
    step(3'b001, 1'b1, 8'hAA);
    check("R7 out strobe", 32'(out_stb_o), 32'(24'h1 << (port - 5'd8)));
    check("R7 no drive", {bus_oe_o, 7'b0, in_stb_o}, 0);
    idle();
  endtask

  task automatic t_interrupt();
    int_vec_i = 3'd5;
    @(negedge clk); int_req_i = 1'b1;
    @(negedge clk); int_req_i = 1'b0;
    idle(); idle();
    addr(1'b1, 2'b00, 14'h0222);
    mem_rdata_i = 8'hFF;
    step(3'b001, 1'b1, 8'h00);
    check("R8 jam byte", {23'b0, bus_oe_o, bus_out_o}, 32'h12D);
    check("R8 no mem rd", 32'(mem_rd_o), 0);
    idle();
    check("R2 ack low addr", 32'(mar_o[7:0]), 32'h22);
    fetch(14'h0223, 8'h5A);
    check("R9 cleared", {23'b0, mem_rd_o, bus_out_o}, 32'h15A);
    idle();
  endtask

  task automatic t_no_ack();
    int_vec_i = 3'd2;
    @(negedge clk); int_req_i = 1'b1;
    @(negedge clk); int_req_i = 1'b0;
    fetch(14'h0300, 8'h11);
    check("R10 plain fetch", {23'b0, mem_rd_o, bus_out_o}, 32'h111);
    idle();
    addr(1'b1, 2'b00, 14'h0301);
    step(3'b001, 1'b1, 8'h00);
    check("R10 later ack jams", 32'(bus_out_o), 32'h15);
    idle();
  endtask

  task automatic t_no_sync();
    addr(1'b0, 2'b01, 14'h0F0F);
    idle();
    step(3'b010, 1'b0, 8'hEE);
    step(3'b100, 1'b0, 8'hFF);
    step(3'b001, 1'b0, 8'h00);
    check("R11 no strobe", {mem_rd_o, mem_wr_o, bus_oe_o}, 0);
    idle();
    check("R11 mar held", 32'(mar_o), 32'h0F0F);
    check("R11 cyc held", 32'(cyc_o), 32'h1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_i = '0; st_i = '0; sync_i = 1'b0;
    int_req_i = 1'b0; int_vec_i = '0; mem_rdata_i = '0; io_rdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    t_reset();
    t_addr();
    t_mem_read();
    t_mem_write();
    t_input();
    t_output(5'd8);
    t_output(5'd18);
    t_interrupt();
    t_no_ack();
    t_no_sync();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule